// File: doc/BRIEF.md
# Program Counter Watchdog Monitor

This block watches the program counter of a processing core that works on blocks of audio spanning several samples. When the counter reaches a limit that software programs, the block raises an error. The error is sticky. It drives a level output meant for a multipurpose pin, for example to interrupt a host controller. A mute-control register can turn that watchdog error, or an externally supplied CRC error, into an automatic mute request to the core.

Software reaches the block through a small 16-bit register port. The port has an enable register, the limit split into 16-bit segments, a mute-control register and a read-only status register. Writes happen synchronously when `wr_en` is high, and reads are combinational on `addr`. The upper limit segments collect in a staging register. The whole limit takes effect only when the lowest segment is written, so a half-updated value can never produce a false match.

Top module: `pcwd_monitor`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) clears the enable, limit, mute-control, staging and CRC-sticky state. While in reset, `err_o` and `mute_o` read 0 and every register reads 0.
- R2: Address 0 is the enable register. Only bit 0 is stored, and bits 15:1 read back as zero whatever was written.
- R3: Address 1 holds the upper 16 limit bits and address 2 the lower 16 limit bits, with the default 32-bit limit and 16-bit data. Each reads back the value last written to it.
- R4: A write to address 1 alone does not change the active limit. The full limit becomes active at the clock edge that writes address 2.
- R5: With enable at 1, `err_o` goes high at the clock edge after the one at which `pc_i` equals the active limit. The edge that writes the enable bit still uses the old enable value. With enable at 0, a match never raises `err_o`.
- R6: Once set, `err_o` stays high while `pc_i` moves away from the limit.
- R7: Writing 0 to enable bit 0 clears `err_o` at that clock edge, even if a match is present on the same edge. Writing 1 while the error is set leaves it set.
- R8: Address 4 is the read-only status register. Bit 0 mirrors the sticky watchdog error and bits 15:1 read zero. Writes to it have no effect.
- R9: Address 3 is mute control. Bit 0 enables mute on watchdog error and bit 1 enables mute on CRC error. Bits 15:2 read zero.
- R10: `mute_o` = (watchdog error AND bit 0) OR (CRC sticky AND bit 1). The CRC sticky is set by `crc_err_i` high at a clock edge and is cleared only by reset.
- R11: Addresses 5 to 15 read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Combinational read data for `addr` |
| pc_i | input | 32 | Monitored program counter |
| crc_err_i | input | 1 | CRC error indication from the checker |
| err_o | output | 1 | Sticky watchdog error level for a multipurpose pin |
| mute_o | output | 1 | Automatic mute request to the core |

## Verification
The bench builds the block with its defaults: 16-bit data, a 32-bit program counter split into two segments, and a combinational mute output. The two-segment split is what makes the staging path observable. A counter value equal to only the newly written upper half must not match until the lower half is written. The bench also reaches the same-edge collision of a clear write with a live match, and the one-edge lag between an enable write and the first possible error.

// File: rtl/pcwd_pkg.sv
package pcwd_pkg;

   typedef enum logic [2:0] {
      RK_ENABLE = 3'd0,
      RK_LIMIT  = 3'd1,
      RK_MUTE   = 3'd2,
      RK_STATUS = 3'd3,
      RK_NONE   = 3'd4
   } reg_kind_e;

   // Map: 0 enable, 1..nseg limit segments (most significant first),
   // nseg+1 mute control, nseg+2 status.
   function automatic reg_kind_e decode_addr(input int unsigned a, input int unsigned nseg);
      if (a == 0)                return RK_ENABLE;
      else if (a <= nseg)        return RK_LIMIT;
      else if (a == nseg + 1)    return RK_MUTE;
      else if (a == nseg + 2)    return RK_STATUS;
      else                       return RK_NONE;
   endfunction

endpackage

// File: rtl/pcwd_regs.sv
module pcwd_regs
   import pcwd_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int NSEG   = 2,
   parameter int ADDR_W = 4,
   localparam int LIM_W = NSEG * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              stat_i,
   output logic              en_o,
   output logic              clr_o,
   output logic [LIM_W-1:0]  limit_o,
   output logic [1:0]        mute_cfg_o
);

   reg_kind_e          kind;
   logic               we_en, we_mute;
   logic [NSEG-1:0]    we_seg;
   logic               commit;
   logic [DATA_W-1:0]  rb_seg [NSEG];
   logic               en_q;
   logic [1:0]         mute_q;

   assign kind    = decode_addr(int'(addr), NSEG);
   assign we_en   = wr_en && (kind == RK_ENABLE);
   assign we_mute = wr_en && (kind == RK_MUTE);
   assign commit  = we_seg[NSEG-1];
   assign clr_o   = we_en && !wr_data[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mute_q <= 2'b00;
      end else begin
         if (we_en)   en_q   <= wr_data[0];
         if (we_mute) mute_q <= wr_data[1:0];
      end
   end

   assign en_o       = en_q;
   assign mute_cfg_o = mute_q;

   // One slice per limit segment; s = 0 is the most significant.
   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      localparam int LSB = (NSEG - 1 - s) * DATA_W;
      logic [DATA_W-1:0] act_q;

      assign we_seg[s] = wr_en && (addr == ADDR_W'(s + 1));
      assign limit_o[LSB +: DATA_W] = act_q;

      if (s < NSEG - 1) begin : g_staged
         logic [DATA_W-1:0] stage_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               stage_q <= '0;
               act_q   <= '0;
            end else begin
               if (we_seg[s]) stage_q <= wr_data;
               if (commit)    act_q   <= stage_q;
            end
         end
         assign rb_seg[s] = stage_q;
      end else begin : g_commit
         always_ff @(posedge clk) begin
            if (!rst_n)      act_q <= '0;
            else if (commit) act_q <= wr_data;
         end
         assign rb_seg[s] = act_q;
      end
   end

   always_comb begin
      rd_data = '0;
      unique case (kind)
         RK_ENABLE: rd_data[0]   = en_q;
         RK_MUTE:   rd_data[1:0] = mute_q;
         RK_STATUS: rd_data[0]   = stat_i;
         RK_LIMIT: begin
            for (int s = 0; s < NSEG; s++)
               if (addr == ADDR_W'(s + 1)) rd_data = rb_seg[s];
         end
         default:   rd_data = '0;
      endcase
   end

   AST_LIMIT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(limit_o)); // R4
   AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && kind == RK_STATUS) |=> ($stable(en_q) && $stable(mute_q) && $stable(limit_o))); // R8

endmodule

// File: rtl/pcwd_match.sv
module pcwd_match #(
   parameter int DATA_W = 16,
   parameter int NSEG   = 2,
   localparam int PC_W  = NSEG * DATA_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en_i,
   input  logic            clr_i,
   input  logic [PC_W-1:0] pc_i,
   input  logic [PC_W-1:0] limit_i,
   output logic            err_o
);

   logic [NSEG-1:0] seg_eq;
   logic            hit;
   logic            err_q;

   // Equality split into data-width slices, reduced by an AND tree.
   for (genvar s = 0; s < NSEG; s++) begin : g_cmp
      assign seg_eq[s] = (pc_i[s*DATA_W +: DATA_W] == limit_i[s*DATA_W +: DATA_W]);
   end
   assign hit = en_i && (&seg_eq);

   always_ff @(posedge clk) begin
      if (!rst_n)     err_q <= 1'b0;
      else if (clr_i) err_q <= 1'b0;
      else if (hit)   err_q <= 1'b1;
   end

   assign err_o = err_q;

   AST_ERR_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> $past(en_i && (pc_i == limit_i))); // R5
   AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !$rose(err_q)); // R5
   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !clr_i) |=> err_q); // R6
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !err_q); // R7

endmodule

// File: rtl/pcwd_mute.sv
module pcwd_mute #(
   parameter bit MUTE_REGISTERED = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       crc_err_i,
   input  logic       wd_err_i,
   input  logic [1:0] cfg_i,
   output logic       mute_o
);

   logic crc_q;
   logic mute_d;

   always_ff @(posedge clk) begin
      if (!rst_n)         crc_q <= 1'b0;
      else if (crc_err_i) crc_q <= 1'b1;
   end

   assign mute_d = (wd_err_i && cfg_i[0]) || (crc_q && cfg_i[1]);

   if (MUTE_REGISTERED) begin : g_reg
      logic mute_q;
      always_ff @(posedge clk) begin
         if (!rst_n) mute_q <= 1'b0;
         else        mute_q <= mute_d;
      end
      assign mute_o = mute_q;
   end else begin : g_comb
      assign mute_o = mute_d;
      AST_MUTE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
         mute_o |-> (wd_err_i || crc_q)); // R10
   end

   AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      crc_q |=> crc_q); // R10

endmodule

// File: rtl/pcwd_monitor.sv
module pcwd_monitor #(
   parameter int DATA_W          = 16,
   parameter int PC_W            = 32,
   parameter int ADDR_W          = 4,
   parameter bit MUTE_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [PC_W-1:0]   pc_i,
   input  logic              crc_err_i,
   output logic              err_o,
   output logic              mute_o
);

   localparam int NSEG   = PC_W / DATA_W;
   localparam int NREGS  = NSEG + 3;
   localparam int NEED_A = $clog2(NREGS);

   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end
   if (PC_W != NSEG * DATA_W || NSEG < 1) begin : g_bad_split
      $error("PC_W must be a nonzero multiple of DATA_W");
   end
   if (ADDR_W < NEED_A) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic              en;
   logic              clr;
   logic [PC_W-1:0]   limit;
   logic [1:0]        mute_cfg;
   logic              wd_err;

   pcwd_regs #(.DATA_W(DATA_W), .NSEG(NSEG), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .addr       (addr),
      .wr_data    (wr_data),
      .rd_data    (rd_data),
      .stat_i     (wd_err),
      .en_o       (en),
      .clr_o      (clr),
      .limit_o    (limit),
      .mute_cfg_o (mute_cfg)
   );

   pcwd_match #(.DATA_W(DATA_W), .NSEG(NSEG)) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (en),
      .clr_i   (clr),
      .pc_i    (pc_i),
      .limit_i (limit),
      .err_o   (wd_err)
   );

   pcwd_mute #(.MUTE_REGISTERED(MUTE_REGISTERED)) u_mute (
      .clk       (clk),
      .rst_n     (rst_n),
      .crc_err_i (crc_err_i),
      .wd_err_i  (wd_err),
      .cfg_i     (mute_cfg),
      .mute_o    (mute_o)
   );

   assign err_o = wd_err;

endmodule

// File: tb/sim_pcwd_monitor.sv
module sim_pcwd_monitor;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [31:0] pc_i = 32'h100;
   logic        crc_err_i = 1'b0;
   logic        err_o, mute_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   pcwd_monitor u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .rd_data(rd_data), .pc_i(pc_i), .crc_err_i(crc_err_i),
      .err_o(err_o), .mute_o(mute_o)
   );

   // {op[1:0], addr[3:0], data[15:0], pc[31:0], crc, exp_rd[15:0], exp_err, exp_mute}
   // op: 0 idle, 1 write, 2 read check
   localparam int NV = 27;
   localparam logic [72:0] VEC [NV] = '{
      {2'd2, 4'h0, 16'h0000, 32'h0000_0100, 1'b0, 16'h0000, 1'b0, 1'b0}, // R1
      {2'd1, 4'h1, 16'h0001, 32'h0000_0100, 1'b0, 16'h0000, 1'b0, 1'b0},
      {2'd2, 4'h1, 16'h0000, 32'h0000_0100, 1'b0, 16'h0001, 1'b0, 1'b0}, // R3
      {2'd1, 4'h0, 16'hFFFF, 32'h0000_0100, 1'b0, 16'h0000, 1'b0, 1'b0},
      {2'd2, 4'h0, 16'h0000, 32'h0000_0100, 1'b0, 16'h0001, 1'b0, 1'b0}, // R2
      {2'd0, 4'h0, 16'h0000, 32'h0001_0000, 1'b0, 16'h0000, 1'b0, 1'b0}, // R4
      {2'd1, 4'h2, 16'h0020, 32'h0000_0100, 1'b0, 16'h0000, 1'b0, 1'b0},
      {2'd2, 4'h2, 16'h0000, 32'h0000_0100, 1'b0, 16'h0020, 1'b0, 1'b0}, // R3
      {2'd0, 4'h0, 16'h0000, 32'h0001_001F, 1'b0, 16'h0000, 1'b0, 1'b0},
      {2'd0, 4'h0, 16'h0000, 32'h0001_0020, 1'b0, 16'h0000, 1'b1, 1'b0}, // R5
      {2'd0, 4'h0, 16'h0000, 32'h0001_0021, 1'b0, 16'h0000, 1'b1, 1'b0}, // R6
      {2'd2, 4'h4, 16'h0000, 32'h0000_0100, 1'b0, 16'h0001, 1'b1, 1'b0}, // R8
      {2'd1, 4'h4, 16'h0000, 32'h0000_0100, 1'b0, 16'h0000, 1'b1, 1'b0},
      {2'd2, 4'h4, 16'h0000, 32'h0000_0100, 1'b0, 16'h0001, 1'b1, 1'b0}, // R8
      {2'd1, 4'h3, 16'hFFFD, 32'h0000_0100, 1'b0, 16'h0000, 1'b1, 1'b1}, // R10
      {2'd2, 4'h3, 16'h0000, 32'h0000_0100, 1'b0, 16'h0001, 1'b1, 1'b1}, // R9
      {2'd1, 4'h0, 16'h0000, 32'h0000_0100, 1'b0, 16'h0000, 1'b0, 1'b0}, // R7
      {2'd0, 4'h0, 16'h0000, 32'h0001_0020, 1'b0, 16'h0000, 1'b0, 1'b0}, // R5
      {2'd2, 4'h4, 16'h0000, 32'h0000_0100, 1'b0, 16'h0000, 1'b0, 1'b0}, // R7
      {2'd1, 4'h7, 16'hABCD, 32'h0000_0100, 1'b0, 16'h0000, 1'b0, 1'b0},
      {2'd2, 4'h7, 16'h0000, 32'h0000_0100, 1'b0, 16'h0000, 1'b0, 1'b0}, // R11
      {2'd2, 4'h5, 16'h0000, 32'h0000_0100, 1'b0, 16'h0000, 1'b0, 1'b0}, // R11
      {2'd0, 4'h0, 16'h0000, 32'h0000_0100, 1'b1, 16'h0000, 1'b0, 1'b0}, // R10
      {2'd1, 4'h3, 16'h0002, 32'h0000_0100, 1'b0, 16'h0000, 1'b0, 1'b1}, // R10
      {2'd2, 4'h3, 16'h0000, 32'h0000_0100, 1'b0, 16'h0002, 1'b0, 1'b1}, // R9
      {2'd1, 4'h0, 16'h0001, 32'h0000_0100, 1'b0, 16'h0000, 1'b0, 1'b1},
      {2'd0, 4'h0, 16'h0000, 32'h0001_0020, 1'b0, 16'h0000, 1'b1, 1'b1}  // R5
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Drive at negedge, let one rising edge pass, return 1 ns after it.
   task automatic step(input logic w, input logic [3:0] a, input logic [15:0] d,
                       input logic [31:0] pc, input logic crc);
      @(negedge clk);
      wr_en = w; addr = a; wr_data = d; pc_i = pc; crc_err_i = crc;
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 err in reset", {31'b0, err_o}, 32'd0);
      check("R1 mute in reset", {31'b0, mute_o}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [72:0] v;
         v = VEC[i];
         @(negedge clk);
         wr_en     = (v[72:71] == 2'd1);
         addr      = v[70:67];
         wr_data   = v[66:51];
         pc_i      = v[50:19];
         crc_err_i = v[18];
         #1;
         if (v[72:71] == 2'd2)
            check($sformatf("R2/R3/R8/R9/R11 read step %0d", i), {16'b0, rd_data}, {16'b0, v[17:2]});
         @(posedge clk);
         #1;
         check($sformatf("R5/R6/R7 err step %0d", i), {31'b0, err_o}, {31'b0, v[1]});
         check($sformatf("R10 mute step %0d", i), {31'b0, mute_o}, {31'b0, v[0]});
      end

      // R1: reset mid-run clears all state
      @(negedge clk);
      wr_en = 1'b0; rst_n = 1'b0;
      @(posedge clk);
      @(posedge clk);
      #1;
      check("R1 err after reset", {31'b0, err_o}, 32'd0);
      check("R1 mute after reset", {31'b0, mute_o}, 32'd0);
      for (int a = 0; a < 5; a++) begin
         addr = 4'(a);
         #1;
         check($sformatf("R1 reg %0d after reset", a), {16'b0, rd_data}, 32'd0);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R5 latency across the enable write, R7 clear against a live match
      step(1'b1, 4'h2, 16'h0005, 32'h5, 1'b0);
      check("R4 commit, disabled", {31'b0, err_o}, 32'd0);
      step(1'b1, 4'h0, 16'h0001, 32'h5, 1'b0);
      check("R5 enable edge uses old enable", {31'b0, err_o}, 32'd0);
      step(1'b0, 4'h0, 16'h0000, 32'h5, 1'b0);
      check("R5 error one edge after match", {31'b0, err_o}, 32'd1);
      step(1'b1, 4'h0, 16'h0000, 32'h5, 1'b0);
      check("R7 clear wins over match", {31'b0, err_o}, 32'd0);
      step(1'b1, 4'h0, 16'h0001, 32'h5, 1'b0);
      check("R7 re-enable edge", {31'b0, err_o}, 32'd0);
      step(1'b0, 4'h0, 16'h0000, 32'h5, 1'b0);
      check("R5 re-armed match", {31'b0, err_o}, 32'd1);
      step(1'b1, 4'h0, 16'h0001, 32'h6, 1'b0);
      check("R7 writing one keeps error", {31'b0, err_o}, 32'd1);
      check("R10 mute off with cleared config", {31'b0, mute_o}, 32'd0);

      finish_run();
   end

endmodule